// File: doc/BRIEF.md
# Frame Transfer Trigger Controller

This block sequences one rectangular frame transfer from a pixel stream toward a command-mode display. Software loads the number of pixels in the region (width times height) and writes the enable bit. The block then waits for its start condition and opens a ready/valid path for exactly that many pixels. When the last pixel has been handed downstream it raises a one-cycle frame-done pulse and drops its own enable bit. Bus strobe timing and pixel packing sit downstream of the output handshake and are not part of this block.

There are two start conditions. With tearing sync off, the transfer starts as soon as enable is written. With tearing sync on, the block waits for a qualified vsync pulse from the panel. In line mode it then counts qualified hsync pulses until a programmed line number is reached. Each sync input has its own polarity inversion and its own minimum pulse width in clock ticks. Both pass through a two-flop synchronizer. A pulse counts only when its active run is strictly longer than the programmed width. A run that is too short is ignored.

Top module: `frame_xfer_trigger`

## Requirements
- R1: After reset, enableState and frameDone are 0 and no pixel passes: inReady and outValid stay 0 while enableState is 0.
- R2: With syncEnable=0, writing ctrlEnable=1 (ctrlWrite=1) starts streaming on the next cycle. While streaming, outValid follows inValid, inReady follows outReady, and outData equals inData.
- R3: Exactly pixelCount handshakes (outValid and outReady both 1) are passed. On the cycle after the last one, frameDone is 1 for one cycle and enableState is 0. A pixelCount of 0 completes with no handshake.
- R4: With syncEnable=1 and lineMode=0, no pixel passes until a qualified vsync pulse arrives. Streaming then starts.
- R5: A sync pulse qualifies only if its active run lasts more than its min-width value in clock cycles. A run equal to or shorter than that value is ignored.
- R6: With syncEnable=1 and lineMode=1, streaming starts after lineTarget (11 bits) qualified hsync pulses following a qualified vsync. A lineTarget of 0 starts on the vsync itself. A new qualified vsync restarts the line count from zero.
- R7: When hsInvert or vsInvert is 1, the matching sync pin is active low. Otherwise it is active high.
- R8: Writing ctrlEnable=1 while enableState is 1 is ignored. The count loaded at the start is not reloaded.
- R9: Writing ctrlEnable=0 while enableState is 1 aborts the transfer. enableState drops on the next cycle and no frameDone is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrite | input | 1 | Write strobe for the enable bit |
| ctrlEnable | input | 1 | Enable value written with ctrlWrite |
| pixelCount | input | PIX_W | Pixels in the frame, loaded at start |
| syncEnable | input | 1 | 1 = wait for panel sync, 0 = start at once |
| lineMode | input | 1 | 0 = vsync only, 1 = vsync then hsync lines |
| lineTarget | input | LINE_W | Line number to wait for in line mode |
| hsMinWidth | input | TICK_W | hsync width that must be exceeded |
| vsMinWidth | input | TICK_W | vsync width that must be exceeded |
| hsInvert | input | 1 | hsync active low when 1 |
| vsInvert | input | 1 | vsync active low when 1 |
| hsyncPin | input | 1 | Asynchronous hsync from panel |
| vsyncPin | input | 1 | Asynchronous vsync from panel |
| inValid | input | 1 | Upstream pixel valid |
| inReady | output | 1 | Upstream pixel ready |
| inData | input | DATA_W | Upstream pixel |
| outValid | output | 1 | Downstream pixel valid |
| outReady | input | 1 | Downstream pixel ready |
| outData | output | DATA_W | Downstream pixel |
| enableState | output | 1 | Enable bit readback, 1 while a transfer is pending or running |
| frameDone | output | 1 | One-cycle pulse at frame completion |

## Verification
The hardest state to reach is line mode partway through its count, where a second vsync has to reset the hsync tally. The stimulus sends a vsync, one hsync, a second vsync and one more hsync. It then checks that the path is still closed, and that one further hsync opens it. Width qualification is probed at the edge: pulses exactly as wide as the programmed value must be ignored, and pulses one tick wider must count. An enable write mid-stream carries a different pixel count, so the total handshakes show whether it was wrongly reloaded.

// File: rtl/frame_trig_pkg.sv
package frame_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_VS,
    ST_WAIT_LN,
    ST_STREAM
  } trigState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic clearLines;
    logic incLines;
    logic streaming;
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic vsEvent;
    logic hsEvent;
    logic lastPixel;
    logic zeroCount;
    logic lineHit;
    logic lineZero;
  } dpStat_t;

endpackage

// File: rtl/te_pulse_qual.sv
module te_pulse_qual #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              invert,
  input  logic [TICK_W-1:0] minWidth,
  output logic              qualEvent
);

  logic [1:0]        syncQ;
  logic              active;
  logic [TICK_W-1:0] runCnt;
  logic              fired;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], pinIn};
  end

  assign active = syncQ[1] ^ invert;

  // runCnt holds the earlier active cycles of the current run
  assign qualEvent = active && !fired && (runCnt >= minWidth);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      fired  <= 1'b0;
    end else if (!active) begin
      runCnt <= '0;
      fired  <= 1'b0;
    end else begin
      if (runCnt != '1) runCnt <= runCnt + 1'b1;
      if (qualEvent)    fired  <= 1'b1;
    end
  end

endmodule

// File: rtl/frame_trig_datapath.sv
module frame_trig_datapath
  import frame_trig_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 11,
  parameter int TICK_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  input  logic [PIX_W-1:0]  pixelCount,
  input  logic [LINE_W-1:0] lineTarget,
  input  logic [TICK_W-1:0] hsMinWidth,
  input  logic [TICK_W-1:0] vsMinWidth,
  input  logic              hsInvert,
  input  logic              vsInvert,
  input  logic              hsyncPin,
  input  logic              vsyncPin,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  localparam int LCMP_W = LINE_W + 1;

  logic [PIX_W-1:0]  remaining;
  logic [LINE_W-1:0] lineCnt;
  logic              xferFire;

  te_pulse_qual #(.TICK_W(TICK_W)) u_hsQual (
    .clk(clk), .rstN(rstN), .pinIn(hsyncPin), .invert(hsInvert),
    .minWidth(hsMinWidth), .qualEvent(stat.hsEvent)
  );

  te_pulse_qual #(.TICK_W(TICK_W)) u_vsQual (
    .clk(clk), .rstN(rstN), .pinIn(vsyncPin), .invert(vsInvert),
    .minWidth(vsMinWidth), .qualEvent(stat.vsEvent)
  );

  assign outValid = inValid && strb.streaming;
  assign inReady  = outReady && strb.streaming;
  assign outData  = inData;
  assign xferFire = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remaining <= '0;
    else if (strb.loadCount) remaining <= pixelCount;
    else if (xferFire)       remaining <= remaining - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lineCnt <= '0;
    else if (strb.clearLines) lineCnt <= '0;
    else if (strb.incLines)   lineCnt <= lineCnt + 1'b1;
  end

  assign stat.lastPixel = xferFire && (remaining == PIX_W'(1));
  assign stat.zeroCount = (remaining == '0);
  assign stat.lineHit   = (LCMP_W'(lineCnt) + LCMP_W'(1)) == LCMP_W'(lineTarget);
  assign stat.lineZero  = (lineTarget == '0);

endmodule

// File: rtl/frame_trig_ctrl.sv
module frame_trig_ctrl
  import frame_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWrite,
  input  logic      ctrlEnable,
  input  logic      syncEnable,
  input  logic      lineMode,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      enableState,
  output logic      frameDone
);

  trigState_t state, stateNext;
  logic       doneNext;

  always_comb begin
    stateNext      = state;
    doneNext       = 1'b0;
    strb           = '0;
    strb.streaming = (state == ST_STREAM) && !stat.zeroCount;
    if (state != ST_IDLE && ctrlWrite && !ctrlEnable) begin
      stateNext = ST_IDLE;               // abort, no frame-done
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctrlWrite && ctrlEnable) begin
            strb.loadCount  = 1'b1;
            strb.clearLines = 1'b1;
            stateNext       = syncEnable ? ST_WAIT_VS : ST_STREAM;
          end
        end
        ST_WAIT_VS: begin
          if (stat.vsEvent) begin
            strb.clearLines = 1'b1;
            stateNext       = (lineMode && !stat.lineZero) ? ST_WAIT_LN : ST_STREAM;
          end
        end
        ST_WAIT_LN: begin
          if (stat.vsEvent) begin
            strb.clearLines = 1'b1;      // fresh vsync restarts counting
          end else if (stat.hsEvent) begin
            if (stat.lineHit) stateNext     = ST_STREAM;
            else              strb.incLines = 1'b1;
          end
        end
        ST_STREAM: begin
          if (stat.lastPixel || stat.zeroCount) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
    end else begin
      state     <= stateNext;
      frameDone <= doneNext;
    end
  end

  assign enableState = (state != ST_IDLE);

endmodule

// File: rtl/frame_xfer_trigger.sv
module frame_xfer_trigger
  import frame_trig_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 11,
  parameter int TICK_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              ctrlEnable,
  input  logic [PIX_W-1:0]  pixelCount,
  input  logic              syncEnable,
  input  logic              lineMode,
  input  logic [LINE_W-1:0] lineTarget,
  input  logic [TICK_W-1:0] hsMinWidth,
  input  logic [TICK_W-1:0] vsMinWidth,
  input  logic              hsInvert,
  input  logic              vsInvert,
  input  logic              hsyncPin,
  input  logic              vsyncPin,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              enableState,
  output logic              frameDone
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  frame_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
    .syncEnable(syncEnable), .lineMode(lineMode), .stat(stat), .strb(strb),
    .enableState(enableState), .frameDone(frameDone)
  );

  frame_trig_datapath #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .TICK_W(TICK_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .pixelCount(pixelCount), .lineTarget(lineTarget),
    .hsMinWidth(hsMinWidth), .vsMinWidth(vsMinWidth),
    .hsInvert(hsInvert), .vsInvert(vsInvert),
    .hsyncPin(hsyncPin), .vsyncPin(vsyncPin),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

endmodule

// File: rtl/frame_xfer_trigger_chk.sv
module frame_xfer_trigger_chk (
  input logic clk,
  input logic rstN,
  input logic ctrlWrite,
  input logic ctrlEnable,
  input logic enableState,
  input logic frameDone,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outReady
);

  a_r1_idle_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !enableState |-> (!inReady && !outValid));

  a_r2_valid_from_source: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inValid);

  a_r2_ready_from_sink: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

  a_r3_done_clears_enable: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !enableState);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(enableState));

  a_r8_busy_enable_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (enableState && ctrlWrite && ctrlEnable) |=> (enableState || frameDone));

  a_r9_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    (enableState && ctrlWrite && !ctrlEnable) |=> (!enableState && !frameDone));

endmodule

bind frame_xfer_trigger frame_xfer_trigger_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
  .enableState(enableState), .frameDone(frameDone), .inValid(inValid),
  .inReady(inReady), .outValid(outValid), .outReady(outReady)
);

// File: tb/sim_frame_xfer_trigger.sv
module sim_frame_xfer_trigger;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  // vector table: vsMinWidth = 3, hsMinWidth = 2 throughout
  localparam int V_TE  [NV] = '{0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int V_MODE[NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_LINE[NV] = '{0, 0, 0, 0, 0, 3, 3, 2, 0};
  localparam int V_CNT [NV] = '{5, 0, 4, 4, 3, 6, 6, 2, 3};
  localparam int V_VSW [NV] = '{0, 0, 5, 3, 4, 6, 6, 6, 6};
  localparam int V_HSW [NV] = '{0, 0, 0, 0, 0, 3, 3, 2, 0};
  localparam int V_NHS [NV] = '{0, 0, 0, 0, 0, 3, 2, 3, 0};
  localparam int V_EXP [NV] = '{1, 1, 1, 0, 1, 1, 0, 0, 1};

  logic        clk = 0;
  logic        rstN = 0;
  logic        ctrlWrite = 0, ctrlEnable = 0;
  logic [15:0] pixelCount = 0;
  logic        syncEnable = 0, lineMode = 0;
  logic [10:0] lineTarget = 0;
  logic [7:0]  hsMinWidth = 8'd2, vsMinWidth = 8'd3;
  logic        hsInvert = 0, vsInvert = 0;
  logic        hsyncPin = 0, vsyncPin = 0;
  logic        inValid = 0, outReady = 1;
  logic [15:0] inData = 0;
  logic        inReady, outValid, enableState, frameDone;
  logic [15:0] outData;

  int testCount = 0;
  int failCount = 0;
  int doneCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_xfer_trigger u0 (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlEnable(ctrlEnable),
    .pixelCount(pixelCount), .syncEnable(syncEnable), .lineMode(lineMode),
    .lineTarget(lineTarget), .hsMinWidth(hsMinWidth), .vsMinWidth(vsMinWidth),
    .hsInvert(hsInvert), .vsInvert(vsInvert), .hsyncPin(hsyncPin),
    .vsyncPin(vsyncPin), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .enableState(enableState), .frameDone(frameDone)
  );

  always @(posedge clk) if (rstN && frameDone) doneCount <= doneCount + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  task automatic writeEn(input bit en);
    ctrlWrite = 1; ctrlEnable = en;
    @(negedge clk);
    ctrlWrite = 0; #1;
  endtask

  task automatic pulseVs(input int w);
    if (w > 0) begin
      vsyncPin = ~vsInvert;
      repeat (w) @(negedge clk);
      vsyncPin = vsInvert;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic pulseHs(input int w);
    hsyncPin = ~hsInvert;
    repeat (w) @(negedge clk);
    hsyncPin = hsInvert;
    repeat (5) @(negedge clk);
  endtask

  // pass up to limit pixels; stop early on frameDone
  task automatic streamPix(input int limit, output int got, output bit doneSeen, output bit dataOk);
    int guard = 0;
    got = 0; doneSeen = 0; dataOk = 1;
    inValid = 1; #1;
    while (got < limit && !doneSeen && guard < 5000) begin
      if (frameDone) doneSeen = 1;
      else if (inReady) begin
        if (!outValid || outData != inData) dataOk = 0;
        got++;
      end
      guard++;
      @(negedge clk);
      inData = inData + 16'h0101; #1;
    end
    inValid = 0; #1;
  endtask

  task automatic runFrame(input int expN, input string req);
    int  got;
    bit  dn, dok;
    streamPix(100000, got, dn, dok);
    check(dn, req, int'(dn), 1);
    check(got == expN, req, got, expN);
    check(dok, "R2 data and valid pass-through", int'(dok), 1);
    check(!enableState, req, int'(enableState), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishUp();
  end

  initial begin
    int got, d0;
    bit dn, dok;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!enableState && !frameDone, "R1 reset enable/done", int'(enableState), 0);
    inValid = 1; #1;
    check(!inReady && !outValid, "R1 reset blocks pixels", int'(inReady), 0);
    inValid = 0;
    rstN = 1;
    repeat (4) @(negedge clk);
    #1;
    check(!inReady && !enableState, "R1 idle after reset", int'(inReady), 0);

    for (int v = 0; v < NV; v++) begin
      syncEnable = V_TE[v][0];
      lineMode   = V_MODE[v][0];
      lineTarget = 11'(V_LINE[v]);
      pixelCount = 16'(V_CNT[v]);
      d0 = doneCount;
      writeEn(1);
      pulseVs(V_VSW[v]);
      for (int h = 0; h < V_NHS[v]; h++) pulseHs(V_HSW[v]);
      #1;
      if (V_EXP[v] == 1) begin
        runFrame(V_CNT[v], "R3 frame count/done (R4 R5 R6 vector)");
      end else begin
        check(enableState && !inReady, "R5 R6 start held back", int'(inReady), 0);
        writeEn(0);
        repeat (3) @(negedge clk); #1;
        check(!enableState && doneCount == d0, "R9 abort while waiting", doneCount - d0, 0);
      end
      repeat (2) @(negedge clk);
    end

    // R7: both syncs active low, line mode, target 1
    hsInvert = 1; vsInvert = 1; hsyncPin = 1; vsyncPin = 1;
    syncEnable = 1; lineMode = 1; lineTarget = 11'd1; pixelCount = 16'd3;
    repeat (4) @(negedge clk);
    writeEn(1);
    repeat (4) @(negedge clk); #1;
    check(!inReady && enableState, "R7 idle-high inverted pins give no start", int'(inReady), 0);
    pulseVs(5);
    pulseHs(4);
    runFrame(3, "R7 inverted polarity start");
    hsInvert = 0; vsInvert = 0; hsyncPin = 0; vsyncPin = 0;
    repeat (4) @(negedge clk);

    // R6: a second vsync restarts the line count
    lineTarget = 11'd2; pixelCount = 16'd2;
    writeEn(1);
    pulseVs(6); pulseHs(3); pulseVs(6); pulseHs(3); #1;
    check(!inReady && enableState, "R6 vsync restart keeps waiting", int'(inReady), 0);
    pulseHs(3);
    runFrame(2, "R6 start after restarted line count");

    // R8: enable write mid-stream ignored, count not reloaded
    syncEnable = 0; pixelCount = 16'd10;
    writeEn(1);
    streamPix(3, got, dn, dok);
    check(got == 3 && !dn, "R8 partial stream", got, 3);
    pixelCount = 16'd50;
    writeEn(1);
    runFrame(7, "R8 busy enable ignored");

    // R9: abort mid-stream
    pixelCount = 16'd20;
    d0 = doneCount;
    writeEn(1);
    streamPix(4, got, dn, dok);
    writeEn(0);
    #1;
    check(!enableState, "R9 abort clears enable", int'(enableState), 0);
    inValid = 1;
    repeat (5) @(negedge clk); #1;
    check(!inReady && !outValid, "R9 path closed after abort", int'(inReady), 0);
    check(doneCount == d0, "R9 no frame-done on abort", doneCount - d0, 0);
    inValid = 0;

    finishUp();
  end

endmodule